// File: doc/BRIEF.md
# Three-Register Bidirectional I/O Port

This block is an 8-bit general-purpose I/O port. Each pin is controlled through three separately addressed registers:
- a direction register;
- an output/pull-up latch;
- a read-only pin-level register that returns the synchronized pad inputs.

A simple register bus gives software access. It has an address, a write enable with write data, and a read enable with registered read data.

On the pad side, the port drives a per-pin output value, output enable and pull-up enable, and samples a per-pin input value. A pin whose direction bit is set drives its latch bit push-pull. A pin whose direction bit is clear is an input, and its latch bit then turns that pin's pull-up on or off.

The latch and the pin level have separate addresses, and reading the latch always returns the stored latch bits. A read-modify-write of the latch therefore copies back the pull-up settings of input pins unchanged, whatever level those pins sit at.

Top module: `io_port_top`

## Requirements
- R1: After a synchronous active-high reset, direction and latch are all zero. padOe, padOut, padPullUp and rdData are all zero, so every pin is an input with its pull-up off.
- R2: A write to address 1 loads the direction register from wrData. padOe equals that value from the next clock, and a read of address 1 returns it. A 1 bit makes its pin an output.
- R3: A write to address 2 loads the latch from wrData, and padOut equals that value from the next clock. Pins whose direction bit is 1 have padOe set and drive their latch bit.
- R4: padPullUp for a pin is 1 exactly when its direction bit is 0 and its latch bit is 1.
- R5: A read of address 2 returns the stored latch contents, never the pin levels. A read-modify-write of the latch therefore leaves the pull-up enables of low input pins unchanged.
- R6: A read of address 0 returns padIn through a two-flop synchronizer. The value returned is the one that padIn held two rising edges before the rising edge that samples rdEn. A read sampled on the first or second edge after a padIn change returns the old level, and a read sampled on the third edge returns the new level.
- R7: Writes to address 0 (pin level, read-only) and to address 3 (unmapped) change no register. A read of address 3 returns zero.
- R8: rdData is registered. It updates on the rising edge that samples rdEn high and holds its value while rdEn is low, even across writes and pin changes.
- R9: When the pad loops back, the pin-level read of an output pin returns the value that pin drives. Input pins return the external level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 2 | Register address: 0 pin level, 1 direction, 2 latch |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Registered read data |
| padIn | input | 8 | Sampled pad levels (asynchronous) |
| padOut | output | 8 | Per-pin output value (latch) |
| padOe | output | 8 | Per-pin output enable (direction) |
| padPullUp | output | 8 | Per-pin pull-up enable |

## Verification
The bench models the pad as a loopback: output pins read back their driven value, and input pins take an external level that the bench sets. Mixed direction and latch patterns, such as 8'hF0 against 8'h5A, separate the pull-up rule from plain direction or latch passthrough. A latch read taken while the input pins are held low shows whether the read returns the stored bits or the pin levels. Three back-to-back pin reads after a single input change show whether the synchronizer is one stage too short or too long.

// File: rtl/io_port_pkg.sv
package io_port_pkg;

  typedef enum logic [1:0] {
    SEL_PIN   = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_LATCH = 2'd2,
    SEL_NONE  = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic    wrDir;
    logic    wrLatch;
    logic    rdStrobe;
    rd_sel_e rdSel;
  } port_strobe_t;

endpackage

// File: rtl/io_port_ctrl.sv
module io_port_ctrl
  import io_port_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int ADDR_PIN   = 0,
  parameter int ADDR_DIR   = 1,
  parameter int ADDR_LATCH = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  output port_strobe_t      strobe
);

  localparam logic [ADDR_W-1:0] A_PIN   = ADDR_W'(ADDR_PIN);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(ADDR_DIR);
  localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(ADDR_LATCH);

  always_comb begin
    strobe          = '0;
    strobe.wrDir    = wrEn && (busAddr == A_DIR);
    strobe.wrLatch  = wrEn && (busAddr == A_LATCH);
    strobe.rdStrobe = rdEn;
    if (busAddr == A_PIN)        strobe.rdSel = SEL_PIN;
    else if (busAddr == A_DIR)   strobe.rdSel = SEL_DIR;
    else if (busAddr == A_LATCH) strobe.rdSel = SEL_LATCH;
    else                         strobe.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/io_port_dp.sv
module io_port_dp
  import io_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  port_strobe_t     strobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padPullUp,
  output logic [WIDTH-1:0] rdData
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] latchQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      dirQ   <= '0;
      latchQ <= '0;
    end else begin
      if (strobe.wrDir)   dirQ   <= wrData;
      if (strobe.wrLatch) latchQ <= wrData;
    end
  end

  // Input synchronizer chain
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncQ[0] <= '0;
          else     syncQ[0] <= padIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) syncQ[s] <= '0;
          else     syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  // Pad control, per pin
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_pin
      assign padOe[b]     = dirQ[b];
      assign padOut[b]    = latchQ[b];
      assign padPullUp[b] = ~dirQ[b] & latchQ[b];
    end
  endgenerate

  always_comb begin
    unique case (strobe.rdSel)
      SEL_PIN:   rdNext = syncQ[LAST];
      SEL_DIR:   rdNext = dirQ;
      SEL_LATCH: rdNext = latchQ;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdData <= '0;
    else if (strobe.rdStrobe) rdData <= rdNext;
  end

endmodule

// File: rtl/io_port_top.sv
module io_port_top
  import io_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic [WIDTH-1:0]  wrData,
  input  logic              rdEn,
  output logic [WIDTH-1:0]  rdData,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padPullUp
);

  port_strobe_t strobe;

  io_port_ctrl #(
    .ADDR_W    (ADDR_W),
    .ADDR_PIN  (0),
    .ADDR_DIR  (1),
    .ADDR_LATCH(2)
  ) u_ctrl (
    .busAddr(busAddr),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .strobe (strobe)
  );

  io_port_dp #(
    .WIDTH      (WIDTH),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .wrData   (wrData),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .padPullUp(padPullUp),
    .rdData   (rdData)
  );

endmodule

// File: rtl/io_port_chk.sv
module io_port_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              wrEn,
  input logic [WIDTH-1:0]  wrData,
  input logic              rdEn,
  input logic [WIDTH-1:0]  rdData,
  input logic [WIDTH-1:0]  padIn,
  input logic [WIDTH-1:0]  padOut,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  padPullUp
);

  logic       prevRst = 1'b0;
  logic [1:0] warmCnt = 2'd0;

  always_ff @(posedge clk) begin
    prevRst <= rst;
    if (rst)                  warmCnt <= 2'd0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  // R1: outputs are cleared on the first edge after reset is released
  always_ff @(posedge clk) begin
    if (prevRst && !rst) begin
      p_reset_state_r1: assert (padOe == '0 && padOut == '0 && padPullUp == '0 && rdData == '0)
        else $error("reset state wrong");
    end
  end

  p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wrEn && busAddr == ADDR_W'(1)) |=> padOe == $past(wrData));

  p_latch_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wrEn && busAddr == ADDR_W'(2)) |=> padOut == $past(wrData));

  p_pullup_input_only_r4: assert property (@(posedge clk) disable iff (rst)
    (padPullUp & padOe) == '0);

  p_pullup_follows_latch_r4: assert property (@(posedge clk) disable iff (rst)
    (padPullUp & ~padOut) == '0);

  p_latch_read_r5: assert property (@(posedge clk) disable iff (rst)
    (rdEn && busAddr == ADDR_W'(2)) |=> rdData == padOut);

  p_sync_delay_r6: assert property (@(posedge clk) disable iff (rst)
    (warmCnt == 2'd3 && rdEn && busAddr == ADDR_W'(0)) |=> rdData == $past(padIn, 3));

  p_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && (busAddr == ADDR_W'(1) || busAddr == ADDR_W'(2)))
      |=> ($stable(padOe) && $stable(padOut)));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rdEn |=> $stable(rdData));

endmodule

bind io_port_top io_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busAddr  (busAddr),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .rdEn     (rdEn),
  .rdData   (rdData),
  .padIn    (padIn),
  .padOut   (padOut),
  .padOe    (padOe),
  .padPullUp(padPullUp)
);

// File: tb/sim_io_port_top.sv
`timescale 1ns/1ps
module sim_io_port_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] busAddr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic [7:0] padIn;
  logic [7:0] padOut;
  logic [7:0] padOe;
  logic [7:0] padPullUp;
  logic [7:0] extPins = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // Pad model: output pins loop back their driven value, inputs take extPins
  assign padIn = (padOe & padOut) | (~padOe & extPins);

  io_port_top u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .padPullUp(padPullUp)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge
  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; rdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 padOe", padOe, 8'h00);
    check("R1 padOut", padOut, 8'h00);
    check("R1 padPullUp", padPullUp, 8'h00);
    check("R1 rdData", rdData, 8'h00);
    busRead(2'd1, v); check("R1 dir read", v, 8'h00);
    busRead(2'd2, v); check("R1 latch read", v, 8'h00);
  endtask

  task automatic t_dir;
    logic [7:0] v;
    busWrite(2'd1, 8'hA5);
    check("R2 padOe", padOe, 8'hA5);
    busRead(2'd1, v); check("R2 dir read", v, 8'hA5);
  endtask

  task automatic t_drive;
    busWrite(2'd2, 8'h3C);
    busWrite(2'd1, 8'hFF);
    check("R3 padOut", padOut, 8'h3C);
    check("R3 padOe", padOe, 8'hFF);
    check("R3 no pullup on outputs", padPullUp, 8'h00);
  endtask

  task automatic t_pullup;
    busWrite(2'd1, 8'hF0);
    busWrite(2'd2, 8'h5A);
    check("R4 pullup mix", padPullUp, 8'h0A);
    busWrite(2'd1, 8'h00);
    check("R4 pullup all inputs", padPullUp, 8'h5A);
  endtask

  task automatic t_rmw;
    logic [7:0] v;
    extPins = 8'h00;
    busWrite(2'd1, 8'h0F);
    busWrite(2'd2, 8'hF0);
    idle(3);
    busRead(2'd2, v); check("R5 latch read not pins", v, 8'hF0);
    busWrite(2'd2, v | 8'h01);
    check("R5 pullups kept after rmw", padPullUp, 8'hF0);
    check("R5 driven bit set", padOut, 8'hF1);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    busWrite(2'd1, 8'h00);
    extPins = 8'h00;
    idle(4);
    extPins = 8'hC3;
    busRead(2'd0, v); check("R6 first edge old", v, 8'h00);
    busRead(2'd0, v); check("R6 second edge old", v, 8'h00);
    busRead(2'd0, v); check("R6 third edge new", v, 8'hC3);
  endtask

  task automatic t_ignore;
    logic [7:0] v;
    busWrite(2'd1, 8'h33);
    busWrite(2'd2, 8'h66);
    busWrite(2'd0, 8'hFF);
    busWrite(2'd3, 8'hFF);
    check("R7 padOe unchanged", padOe, 8'h33);
    check("R7 padOut unchanged", padOut, 8'h66);
    busRead(2'd1, v); check("R7 dir read unchanged", v, 8'h33);
    busRead(2'd2, v); check("R7 latch read unchanged", v, 8'h66);
    busRead(2'd3, v); check("R7 unmapped reads zero", v, 8'h00);
  endtask

  task automatic t_hold;
    logic [7:0] v;
    busRead(2'd1, v);
    busWrite(2'd1, 8'h99);
    extPins = 8'h7E;
    idle(3);
    check("R8 rdData held", rdData, 8'h33);
  endtask

  task automatic t_loop;
    logic [7:0] v;
    busWrite(2'd1, 8'h0F);
    busWrite(2'd2, 8'h05);
    extPins = 8'hA0;
    idle(3);
    busRead(2'd0, v); check("R9 loopback pins", v, 8'hA5);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    t_reset();
    t_dir();
    t_drive();
    t_pullup();
    t_rmw();
    t_sync();
    t_ignore();
    t_hold();
    t_loop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule